// File: doc/BRIEF.md
# Hashed inverted page table lookup

This block translates a (virtual page, process) pair into the physical frame that holds it. The table behind it has exactly one entry per physical frame, so its size is fixed by the amount of physical memory, and the index of an entry is the frame number. Each entry stores a valid flag, the virtual page number and process identifier of the page held in that frame, a small field of control bits, and a chain link. The link is a continue flag plus a next-entry index.

A request is accepted on a valid/ready handshake. The block hashes the key to pick a starting entry and then reads one entry per cycle. It compares the entry with the key and, on a mismatch, follows the chain link. The walk ends on the first match, on an entry whose valid flag is clear, on an entry whose continue flag is clear, or when the number of probes reaches the table size. The last case stops chain loops. The result waits on the response handshake. Only one lookup is in flight at a time. Software, or a refill agent, loads entries through a single write port.

Top module: `ipt_lookup`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The first probed entry has index H = low `$clog2(FRAMES)` bits of the virtual page number XOR (process identifier, XOR-folded to that width, then rotated left by one bit). With the defaults this is H = vpn[3:0] ^ {pid[2:0], pid[3]}.
- R3: On a hit, `rsp_hit`=1. `rsp_frame` is the index of the matching entry, and `rsp_ctl` is that entry's control bits.
- R4: On a mismatch at an entry that is valid and whose continue flag is set, the next probe reads the entry named by its next index. `rsp_probes` equals the number of entries read, including the last one.
- R5: Reading an entry whose valid flag is clear ends the walk with a miss. That read is counted in `rsp_probes`.
- R6: Reading a valid, mismatching entry whose continue flag is clear ends the walk with a miss.
- R7: A walk that reaches FRAMES probes without a match ends with a miss and `rsp_probes` = FRAMES, even when the chain loops.
- R8: A match requires both the virtual page number and the process identifier to be equal. An entry equal in only one of them is a mismatch.
- R9: From the accepting edge until the response is taken, `req_ready` is 0. While `rsp_valid` is 1 and `rsp_ready` is 0, the response outputs hold steady.
- R10: Each probe takes one cycle. `rsp_valid` rises exactly `rsp_probes` clock edges after the edge that accepted the request.
- R11: A table write on the accepting edge is seen by the first probe. A write on the edge that ends a probe is not seen by that probe.
- R12: On a miss, `rsp_frame` and `rsp_ctl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle, request accepted this edge if valid |
| req_vpn | input | VPN_W | Virtual page number to find |
| req_pid | input | PID_W | Process identifier to find |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result taken this edge if valid |
| rsp_hit | output | 1 | 1 when a matching entry was found |
| rsp_frame | output | $clog2(FRAMES) | Frame number (entry index) on a hit, 0 on a miss |
| rsp_probes | output | $clog2(FRAMES+1) | Number of entries read by the walk |
| rsp_ctl | output | CTL_W | Control bits of the hit entry, 0 on a miss |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | $clog2(FRAMES) | Entry to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_vpn | input | VPN_W | Virtual page number to store |
| wr_pid | input | PID_W | Process identifier to store |
| wr_ctl | input | CTL_W | Control bits to store |
| wr_link | input | 1 | Continue flag to store |
| wr_next | input | $clog2(FRAMES) | Next entry index to store |

## Verification
The table write port and the walker's read of the table can act in the same cycle, and the order between them decides the result. The bench drives a write into the starting entry on the same edge that accepts the request, and expects the first probe to see the new contents. It then drives a write that invalidates the entry during the first probe cycle, and expects a hit based on the old contents. A later lookup must show the invalidation. A bench-side model of the table and walk is updated at the edge it expects each write to land, and gives the expected hit, frame, control bits and probe count.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_RESP = 2'd2
  } walk_state_t;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int VPN_W = 8,
  parameter int PID_W = 4,
  parameter int IDX_W = 4
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [PID_W-1:0] pid,
  output logic [IDX_W-1:0] idx
);
  // XOR-fold the process identifier into IDX_W bits
  function automatic logic [IDX_W-1:0] fold_pid(input logic [PID_W-1:0] p);
    logic [IDX_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < PID_W; i++) acc[i % IDX_W] ^= p[i];
    return acc;
  endfunction

  function automatic logic [IDX_W-1:0] rotl1(input logic [IDX_W-1:0] x);
    return {x[IDX_W-2:0], x[IDX_W-1]};
  endfunction

  assign idx = vpn[IDX_W-1:0] ^ rotl1(fold_pid(pid));
endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int FRAMES = 16,
  parameter int VPN_W  = 8,
  parameter int PID_W  = 4,
  parameter int CTL_W  = 2,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [CTL_W-1:0] wr_ctl,
  input  logic             wr_link,
  input  logic [IDX_W-1:0] wr_next,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [VPN_W-1:0] rd_vpn,
  output logic [PID_W-1:0] rd_pid,
  output logic [CTL_W-1:0] rd_ctl,
  output logic             rd_link,
  output logic [IDX_W-1:0] rd_next
);
  localparam int DW = VPN_W + PID_W + CTL_W + 1 + IDX_W;

  logic [FRAMES-1:0] vld_q;
  logic [DW-1:0]     body_q [FRAMES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) body_q[wr_idx] <= {wr_vpn, wr_pid, wr_ctl, wr_link, wr_next};
  end

  assign rd_valid = vld_q[rd_idx];
  assign {rd_vpn, rd_pid, rd_ctl, rd_link, rd_next} = body_q[rd_idx];
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int VPN_W  = 8,
  parameter int PID_W  = 4,
  parameter int CTL_W  = 2,
  localparam int IDX_W = $clog2(FRAMES),
  localparam int CNT_W = $clog2(FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [PID_W-1:0] req_pid,
  input  logic [IDX_W-1:0] start_idx,
  output logic [IDX_W-1:0] probe_idx,
  input  logic             rd_valid,
  input  logic [VPN_W-1:0] rd_vpn,
  input  logic [PID_W-1:0] rd_pid,
  input  logic [CTL_W-1:0] rd_ctl,
  input  logic             rd_link,
  input  logic [IDX_W-1:0] rd_next,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_frame,
  output logic [CNT_W-1:0] rsp_probes,
  output logic [CTL_W-1:0] rsp_ctl,
  output logic             probe_fire,
  output logic             probe_match,
  output logic             walk_end
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FRAMES);

  walk_state_t      state_q;
  logic [VPN_W-1:0] key_vpn_q;
  logic [PID_W-1:0] key_pid_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] probes_now;
  logic             chain_stop;

  assign req_ready   = (state_q == ST_IDLE);
  assign rsp_valid   = (state_q == ST_RESP);
  assign probe_idx   = idx_q;
  assign probe_fire  = (state_q == ST_WALK);
  assign probe_match = probe_fire && rd_valid && (rd_vpn == key_vpn_q) && (rd_pid == key_pid_q);
  assign probes_now  = cnt_q + CNT_W'(1);
  assign chain_stop  = !rd_valid || !rd_link || (probes_now == LIMIT);
  assign walk_end    = probe_fire && (probe_match || chain_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      key_vpn_q  <= '0;
      key_pid_q  <= '0;
      idx_q      <= '0;
      cnt_q      <= '0;
      rsp_hit    <= 1'b0;
      rsp_frame  <= '0;
      rsp_probes <= '0;
      rsp_ctl    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          key_vpn_q <= req_vpn;
          key_pid_q <= req_pid;
          idx_q     <= start_idx;
          cnt_q     <= '0;
          state_q   <= ST_WALK;
        end
        ST_WALK: begin
          if (probe_match) begin
            rsp_hit    <= 1'b1;
            rsp_frame  <= idx_q;
            rsp_ctl    <= rd_ctl;
            rsp_probes <= probes_now;
            state_q    <= ST_RESP;
          end else if (chain_stop) begin
            rsp_hit    <= 1'b0;
            rsp_frame  <= '0;
            rsp_ctl    <= '0;
            rsp_probes <= probes_now;
            state_q    <= ST_RESP;
          end else begin
            idx_q <= rd_next;
            cnt_q <= probes_now;
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int FRAMES = 16,
  parameter int VPN_W  = 8,
  parameter int PID_W  = 4,
  parameter int CTL_W  = 2,
  localparam int IDX_W = $clog2(FRAMES),
  localparam int CNT_W = $clog2(FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [PID_W-1:0] req_pid,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_frame,
  output logic [CNT_W-1:0] rsp_probes,
  output logic [CTL_W-1:0] rsp_ctl,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [CTL_W-1:0] wr_ctl,
  input  logic             wr_link,
  input  logic [IDX_W-1:0] wr_next
);
  logic [IDX_W-1:0] start_idx;
  logic [IDX_W-1:0] probe_idx;
  logic             rd_valid;
  logic [VPN_W-1:0] rd_vpn;
  logic [PID_W-1:0] rd_pid;
  logic [CTL_W-1:0] rd_ctl;
  logic             rd_link;
  logic [IDX_W-1:0] rd_next;
  logic             probe_fire;
  logic             probe_match;
  logic             walk_end;

  ipt_hash #(.VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W)) u_hash (
    .vpn(req_vpn), .pid(req_pid), .idx(start_idx)
  );

  ipt_table #(.FRAMES(FRAMES), .VPN_W(VPN_W), .PID_W(PID_W), .CTL_W(CTL_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_vpn(wr_vpn),
    .wr_pid(wr_pid), .wr_ctl(wr_ctl), .wr_link(wr_link), .wr_next(wr_next),
    .rd_idx(probe_idx), .rd_valid(rd_valid), .rd_vpn(rd_vpn), .rd_pid(rd_pid),
    .rd_ctl(rd_ctl), .rd_link(rd_link), .rd_next(rd_next)
  );

  ipt_walker #(.FRAMES(FRAMES), .VPN_W(VPN_W), .PID_W(PID_W), .CTL_W(CTL_W)) u_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .req_pid(req_pid),
    .start_idx(start_idx), .probe_idx(probe_idx),
    .rd_valid(rd_valid), .rd_vpn(rd_vpn), .rd_pid(rd_pid), .rd_ctl(rd_ctl),
    .rd_link(rd_link), .rd_next(rd_next),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_frame(rsp_frame), .rsp_probes(rsp_probes), .rsp_ctl(rsp_ctl),
    .probe_fire(probe_fire), .probe_match(probe_match), .walk_end(walk_end)
  );
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int FRAMES = 16,
  parameter int CTL_W  = 2,
  localparam int IDX_W = $clog2(FRAMES),
  localparam int CNT_W = $clog2(FRAMES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [IDX_W-1:0] rsp_frame,
  input logic [CNT_W-1:0] rsp_probes,
  input logic [CTL_W-1:0] rsp_ctl,
  input logic             probe_fire,
  input logic             probe_match,
  input logic             walk_end
);
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_frame)
                                   && $stable(rsp_probes) && $stable(rsp_ctl)));

  p_probe_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_probes >= CNT_W'(1) && rsp_probes <= CNT_W'(FRAMES)));

  p_miss_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_frame == '0 && rsp_ctl == '0));

  p_end_gives_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    walk_end |=> rsp_valid);

  p_match_is_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    probe_match |=> (rsp_valid && rsp_hit));

  p_quiet_while_probing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    probe_fire |-> (!rsp_valid && !req_ready));
endmodule

bind ipt_lookup ipt_lookup_chk #(.FRAMES(FRAMES), .CTL_W(CTL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_frame(rsp_frame), .rsp_probes(rsp_probes), .rsp_ctl(rsp_ctl),
  .probe_fire(probe_fire), .probe_match(probe_match), .walk_end(walk_end)
);

// File: tb/ipt_lookup_tb.sv
`timescale 1ns/1ps
module ipt_lookup_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_vpn = '0;
  logic [3:0] req_pid = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic       rsp_hit;
  logic [3:0] rsp_frame;
  logic [4:0] rsp_probes;
  logic [1:0] rsp_ctl;
  logic       wr_en = 1'b0;
  logic [3:0] wr_idx = '0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_vpn = '0;
  logic [3:0] wr_pid = '0;
  logic [1:0] wr_ctl = '0;
  logic       wr_link = 1'b0;
  logic [3:0] wr_next = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench copy of the table
  bit       m_valid [16];
  int       m_vpn   [16];
  int       m_pid   [16];
  int       m_ctl   [16];
  bit       m_link  [16];
  int       m_next  [16];

  always #4 clk = ~clk;

  ipt_lookup u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int hash_b(input int v, input int p);
    return ((v % 16) ^ (((p * 2) % 16) + (p / 8))) % 16;
  endfunction

  task automatic model_walk(input int v, input int p, output bit hit, output int frame,
                            output int probes, output int ctl);
    int idx;
    idx = hash_b(v, p);
    hit = 0; frame = 0; ctl = 0; probes = 0;
    for (int n = 1; n <= 16; n++) begin
      probes = n;
      if (m_valid[idx] && m_vpn[idx] == v && m_pid[idx] == p) begin
        hit = 1; frame = idx; ctl = m_ctl[idx];
        return;
      end
      if (!m_valid[idx] || !m_link[idx] || n == 16) return;
      idx = m_next[idx];
    end
  endtask

  task automatic set_wr(input int idx, input bit v, input int vpn, input int pid,
                        input int ctl, input bit link, input int nxt);
    wr_idx = idx[3:0]; wr_valid = v; wr_vpn = vpn[7:0]; wr_pid = pid[3:0];
    wr_ctl = ctl[1:0]; wr_link = link; wr_next = nxt[3:0];
  endtask

  task automatic model_wr(input int idx, input bit v, input int vpn, input int pid,
                          input int ctl, input bit link, input int nxt);
    m_valid[idx] = v; m_vpn[idx] = vpn; m_pid[idx] = pid;
    m_ctl[idx] = ctl; m_link[idx] = link; m_next[idx] = nxt;
  endtask

  task automatic wr_entry(input int idx, input bit v, input int vpn, input int pid,
                          input int ctl, input bit link, input int nxt);
    @(negedge clk);
    set_wr(idx, v, vpn, pid, ctl, link, nxt);
    wr_en = 1'b1;
    @(posedge clk);
    model_wr(idx, v, vpn, pid, ctl, link, nxt);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // mode 0: plain; 1: write entry on the accepting edge; 2: write during first probe
  task automatic do_lookup(input int v, input int p, input int hold, input string req,
                           input int mode, input int widx, input bit wv, input int wvpn,
                           input int wpid, input int wctl, input bit wlink, input int wnext);
    bit e_hit; int e_frame, e_probes, e_ctl, cyc;
    logic [3:0] f0; logic [4:0] p0; logic h0; logic [1:0] c0;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = v[7:0]; req_pid = p[3:0];
    if (mode == 1) begin set_wr(widx, wv, wvpn, wpid, wctl, wlink, wnext); wr_en = 1'b1; end
    @(posedge clk);
    if (mode == 1) model_wr(widx, wv, wvpn, wpid, wctl, wlink, wnext);
    model_walk(v, p, e_hit, e_frame, e_probes, e_ctl);
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    chk(req_ready == 1'b0, "R9", "req_ready after accept", req_ready, 0);
    if (mode == 2) begin set_wr(widx, wv, wvpn, wpid, wctl, wlink, wnext); wr_en = 1'b1; end
    cyc = 0;
    do begin
      @(posedge clk);
      if (mode == 2 && cyc == 0) model_wr(widx, wv, wvpn, wpid, wctl, wlink, wnext);
      cyc++;
      @(negedge clk);
      wr_en = 1'b0;
    end while (!rsp_valid && cyc < 40);
    chk(rsp_hit == e_hit, req, "hit", rsp_hit, e_hit);
    chk(rsp_frame == e_frame[3:0], req, "frame", rsp_frame, e_frame);
    chk(rsp_ctl == e_ctl[1:0], req, "ctl", rsp_ctl, e_ctl);
    chk(rsp_probes == e_probes[4:0], req, "probes", rsp_probes, e_probes);
    chk(cyc == e_probes, "R10", "latency", cyc, e_probes);
    f0 = rsp_frame; p0 = rsp_probes; h0 = rsp_hit; c0 = rsp_ctl;
    for (int k = 0; k < hold; k++) begin
      @(posedge clk); @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_frame == f0 && rsp_probes == p0 && rsp_hit == h0
          && rsp_ctl == c0, "R9", "response held", rsp_probes, p0);
    end
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R9", "idle after take", req_ready, 1);
  endtask

  task automatic look(input int v, input int p, input string req);
    do_lookup(v, p, 0, req, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run ended)");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model_wr(i, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "idle after reset", rsp_valid, 0);
    for (int i = 0; i < 16; i++) wr_entry(i, 0, 0, 0, 0, 0, 0);

    look(8'h35, 4'h9, "R5");                       // empty table: miss, 1 probe
    wr_entry(6, 1, 8'h35, 4'h9, 2, 0, 0);           // H(35,9) = 5 ^ 3 = 6
    do_lookup(8'h35, 4'h9, 3, "R2", 0, 0, 0, 0, 0, 0, 0, 0);
    look(8'h35, 4'h9, "R3");
    look(8'h33, 4'hA, "R8");                        // same start 6, pid differs
    look(8'h25, 4'h9, "R8");                        // same start 6, vpn differs
    look(8'h25, 4'h9, "R6");
    wr_entry(6, 1, 8'h35, 4'h9, 2, 1, 11);
    wr_entry(11, 1, 8'h33, 4'hA, 1, 1, 2);
    wr_entry(2, 1, 8'h74, 4'h1, 3, 0, 0);
    look(8'h33, 4'hA, "R4");                        // frame 11, 2 probes
    look(8'h74, 4'h1, "R4");                        // frame 2, 3 probes
    do_lookup(8'h84, 4'h1, 0, "R6", 0, 0, 0, 0, 0, 0, 0, 0);
    look(8'h84, 4'h1, "R12");
    wr_entry(2, 1, 8'h74, 4'h1, 3, 1, 9);
    look(8'h84, 4'h1, "R5");                        // invalid entry 9 ends at 4
    wr_entry(2, 1, 8'h74, 4'h1, 3, 1, 6);
    do_lookup(8'h84, 4'h1, 2, "R7", 0, 0, 0, 0, 0, 0, 0, 0);  // loop, 16 probes
    // same-cycle write and probe; H(35,A) = 5 ^ 5 = 0
    do_lookup(8'h35, 4'hA, 0, "R11", 1, 0, 1, 8'h35, 4'hA, 1, 0, 0);
    do_lookup(8'h35, 4'hA, 0, "R11", 2, 0, 0, 8'h35, 4'hA, 1, 0, 0);
    look(8'h35, 4'hA, "R11");

    // sweep over a pattern table
    for (int i = 0; i < 16; i++)
      wr_entry(i, (i % 5) != 0, (i * 7 + 3) % 256, (i * 3) % 16, i % 4, (i % 3) != 0, (i + 5) % 16);
    for (int i = 0; i < 16; i++) look((i * 7 + 3) % 256, (i * 3) % 16, "R3");
    for (int p = 0; p < 16; p++)
      for (int v = 0; v < 32; v++) look(v, p, "R4");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule